// File: doc/BRIEF.md
# Configurable Multi-Function Pin Mapper

This block connects a set of general-purpose port pins to a device's internal control bits and status indicators. Each pin owns a small configuration register that sets its direction and the function it carries. A pin set as an output follows its chosen indicator or control bit combinationally, with no register on the way. A pin set as an input feeds its chosen control bit, and the value is loaded on the strobe clock.

Software reaches the registers over a shared 10-bit address/data bus. The bus is qualified by an active-low port select, a read/write line and the strobe clock. Every access takes two strobes. The first carries the register address. The second carries the write data, or, with the read/write line high, returns the addressed register on the bus. Besides the per-pin configuration registers there is a control register, which holds the control bits the pins can drive, and a read-only status register, which mirrors the live indicators.

The function-select index is 5 bits wide. Index 0 is the null function. Indices 1 up to NUM_CTRL select control bits 0 and upward. Indices 16 up to 16+NUM_STAT-1 select indicators 0 and upward. Every other index is unused.

Top module: `pinmap_top`

## Requirements
- R1: While `rst_n` is low, and at once when it falls, every configuration register is zero, `pin_oe` is all zero, `pin_out` is zero, `ctrl_out` is zero and `bus_oe` is low. Every pin therefore starts as an input mapped to the null function.
- R2: A strobe with `ctl_sel` low and `rd_nwr` low, taken in the address phase, latches `bus_in` as the register address. The next strobe with `ctl_sel` low and `rd_nwr` low writes `bus_in` into that register. The two phases alternate.
- R3: The configuration register of pin i sits at address 0x00F+i, so pins 0 to 7 use 0x00F to 0x016. Bit 5 is the direction (1 = output, 0 = input) and bits 4:0 are the function index. `pin_oe[i]` follows bit 5.
- R4: An output pin drives the current value of its selected indicator or control bit, in the same cycle the source changes, without any strobe.
- R5: Any number of output pins may select the same function, and they all drive the same value.
- R6: An input pin never drives (`pin_oe` low, `pin_out` low). On every strobe with `ctl_sel` low and `rd_nwr` low, in either phase, an input pin mapped to control index 1+k loads its `pin_in` value into control bit k. This capture takes precedence over a bus write to the control register on the same strobe.
- R7: When several input pins map to the same control bit, the lowest-numbered pin decides the value loaded.
- R8: A data-phase strobe with `rd_nwr` high writes nothing. During that phase `bus_out` shows the addressed register, zero-extended, and `bus_oe` is high. `bus_oe` is low at every other time.
- R9: The control register is at address 0x000, holds the control bits in bits NUM_CTRL-1:0 and drives `ctrl_out`. The status register is at address 0x001, is read-only and returns `status_in` in its low bits.
- R10: The null index and unused indices have no effect. An output pin on such an index drives 0. An input pin on such an index, or on an indicator index, changes no control bit.
- R11: Strobes with `ctl_sel` high are ignored. They do not advance the address/data phase and they change no register.
- R12: Writes to any address not listed in R3 and R9 change nothing, and reads from such an address return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| stb_clk | input | 1 | Strobe clock; every rising edge is a strobe |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with stb_clk |
| ctl_sel | input | 1 | Port select, low to address this block |
| rd_nwr | input | 1 | High for a read in the data phase, low for a write |
| bus_in | input | 10 | Multiplexed address/data from the host |
| bus_out | output | 10 | Read data, valid while bus_oe is high |
| bus_oe | output | 1 | Bus output enable for the read data phase |
| pin_in | input | NUM_PINS | Value seen at each port pin |
| pin_out | output | NUM_PINS | Value driven on each port pin |
| pin_oe | output | NUM_PINS | Tristate enable for each port pin |
| status_in | input | NUM_STAT | Live status indicators |
| ctrl_out | output | NUM_CTRL | Control register bits |

## Verification
The bench builds the block with its default parameters: eight pins, eight control bits and eight indicators. With those values it can reach every configuration address, the highest indicator index, and an unused index above the indicators. It can also map two different pins to one control bit in both value orders, which shows which pin takes priority. Because the control register is full width, a bus write and a pin capture can target the same bit on the same strobe, so that conflict is exercised too.

// File: rtl/pinmap_pkg.sv
package pinmap_pkg;

  localparam int BUS_W     = 10;
  localparam int CFG_W     = 6;
  localparam int FN_W      = 5;
  localparam int FN_N      = 1 << FN_W;
  localparam int DIR_BIT   = CFG_W - 1;

  localparam logic [BUS_W-1:0] CTRL_ADDR = 10'h000;
  localparam logic [BUS_W-1:0] STAT_ADDR = 10'h001;
  localparam logic [BUS_W-1:0] CFG_BASE  = 10'h00F;

  // function index layout
  localparam int CTRL_BASE = 1;
  localparam int STAT_BASE = 16;

  typedef logic [CFG_W-1:0] pin_cfg_t;

  typedef enum logic {
    PH_ADDR = 1'b0,
    PH_DATA = 1'b1
  } bus_phase_e;

endpackage

// File: rtl/pinmap_rst_sync.sv
module pinmap_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] shift_q;
  logic [STAGES-1:0] shift_d;

  always_comb begin
    shift_d = {shift_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      shift_q <= '0;
    end else begin
      shift_q <= shift_d;
    end
  end

  assign rst_sync_n = shift_q[STAGES-1];

endmodule

// File: rtl/pinmap_bus_seq.sv
module pinmap_bus_seq
  import pinmap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_sel,
  input  logic             rd_nwr,
  input  logic [BUS_W-1:0] bus_in,
  output logic [BUS_W-1:0] addr_q,
  output logic             wr_en,
  output logic             rd_phase
);

  bus_phase_e       phase_q;
  bus_phase_e       phase_d;
  logic [BUS_W-1:0] addr_d;
  logic             strobe_en;
  logic             addr_en;

  // a strobe counts only while the port is selected
  assign strobe_en = ~ctl_sel;

  always_comb begin
    phase_d = (phase_q == PH_ADDR) ? PH_DATA : PH_ADDR;
    addr_d  = bus_in;
    addr_en = strobe_en && (phase_q == PH_ADDR);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_ADDR;
      addr_q  <= '0;
    end else begin
      if (strobe_en) begin
        phase_q <= phase_d;
      end
      if (addr_en) begin
        addr_q <= addr_d;
      end
    end
  end

  assign wr_en    = strobe_en && (phase_q == PH_DATA) && !rd_nwr;
  assign rd_phase = strobe_en && (phase_q == PH_DATA) && rd_nwr;

endmodule

// File: rtl/pinmap_capture.sv
module pinmap_capture
  import pinmap_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int NUM_CTRL = 8
) (
  input  pin_cfg_t [NUM_PINS-1:0] cfg,
  input  logic     [NUM_PINS-1:0] pin_in,
  output logic     [NUM_CTRL-1:0] cap_hit,
  output logic     [NUM_CTRL-1:0] cap_val
);

  for (genvar k = 0; k < NUM_CTRL; k++) begin : g_bit
    localparam logic [FN_W-1:0] MY_IDX = FN_W'(CTRL_BASE + k);
    logic sel_hit;
    logic sel_val;

    // scan from the top so that the lowest-numbered pin is applied last
    always_comb begin
      sel_hit = 1'b0;
      sel_val = 1'b0;
      for (int p = NUM_PINS - 1; p >= 0; p--) begin
        if (!cfg[p][DIR_BIT] && (cfg[p][FN_W-1:0] == MY_IDX)) begin
          sel_hit = 1'b1;
          sel_val = pin_in[p];
        end
      end
    end

    assign cap_hit[k] = sel_hit;
    assign cap_val[k] = sel_val;
  end

endmodule

// File: rtl/pinmap_regfile.sv
module pinmap_regfile
  import pinmap_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int NUM_CTRL = 8,
  parameter int NUM_STAT = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic     [BUS_W-1:0]    addr,
  input  logic                    wr_en,
  input  logic                    cap_en,
  input  logic     [CFG_W-1:0]    wr_cfg,
  input  logic     [NUM_CTRL-1:0] wr_ctrl,
  input  logic     [NUM_CTRL-1:0] cap_hit,
  input  logic     [NUM_CTRL-1:0] cap_val,
  input  logic     [NUM_STAT-1:0] status,
  output pin_cfg_t [NUM_PINS-1:0] cfg_q,
  output logic     [NUM_CTRL-1:0] ctrl_q,
  output logic     [BUS_W-1:0]    rd_data
);

  logic [NUM_PINS-1:0] cfg_hit;
  logic [NUM_PINS-1:0] cfg_we;
  logic                ctrl_wr;
  logic                ctrl_en;
  logic [NUM_CTRL-1:0] ctrl_d;

  // address decode for the configuration bank
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_dec
    localparam logic [BUS_W-1:0] MY_ADDR = BUS_W'(int'(CFG_BASE) + i);
    assign cfg_hit[i] = (addr == MY_ADDR);
  end

  always_comb begin
    cfg_we  = cfg_hit & {NUM_PINS{wr_en}};
    ctrl_wr = wr_en && (addr == CTRL_ADDR);
    for (int k = 0; k < NUM_CTRL; k++) begin
      if (cap_en && cap_hit[k]) begin
        ctrl_d[k] = cap_val[k];
      end else if (ctrl_wr) begin
        ctrl_d[k] = wr_ctrl[k];
      end else begin
        ctrl_d[k] = ctrl_q[k];
      end
    end
    ctrl_en = ctrl_wr || (cap_en && (|cap_hit));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else begin
      for (int i = 0; i < NUM_PINS; i++) begin
        if (cfg_we[i]) begin
          cfg_q[i] <= wr_cfg;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_en) begin
      ctrl_q <= ctrl_d;
    end
  end

  // read multiplexer
  always_comb begin
    rd_data = '0;
    if (addr == CTRL_ADDR) begin
      rd_data = BUS_W'(ctrl_q);
    end else if (addr == STAT_ADDR) begin
      rd_data = BUS_W'(status);
    end else begin
      for (int i = 0; i < NUM_PINS; i++) begin
        if (cfg_hit[i]) begin
          rd_data = BUS_W'(cfg_q[i]);
        end
      end
    end
  end

endmodule

// File: rtl/pinmap_pin_drv.sv
module pinmap_pin_drv
  import pinmap_pkg::*;
(
  input  pin_cfg_t        cfg,
  input  logic [FN_N-1:0] fn_vec,
  output logic            pin_out,
  output logic            pin_oe
);

  logic is_out;

  assign is_out  = cfg[DIR_BIT];
  assign pin_oe  = is_out;
  assign pin_out = is_out & fn_vec[cfg[FN_W-1:0]];

endmodule

// File: rtl/pinmap_top.sv
module pinmap_top
  import pinmap_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int NUM_CTRL = 8,
  parameter int NUM_STAT = 8
) (
  input  logic                stb_clk,
  input  logic                rst_n,
  input  logic                ctl_sel,
  input  logic                rd_nwr,
  input  logic [BUS_W-1:0]    bus_in,
  output logic [BUS_W-1:0]    bus_out,
  output logic                bus_oe,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  input  logic [NUM_STAT-1:0] status_in,
  output logic [NUM_CTRL-1:0] ctrl_out
);

  logic                    rst_sync_n;
  logic [BUS_W-1:0]        addr_q;
  logic                    wr_en;
  logic                    rd_phase;
  logic                    cap_en;
  logic [NUM_CTRL-1:0]     cap_hit;
  logic [NUM_CTRL-1:0]     cap_val;
  pin_cfg_t [NUM_PINS-1:0] cfg_q;
  logic [NUM_CTRL-1:0]     ctrl_q;
  logic [BUS_W-1:0]        rd_data;
  logic [FN_N-1:0]         fn_vec;

  pinmap_rst_sync #(
    .STAGES(2)
  ) i_rst_sync (
    .clk        (stb_clk),
    .arst_n     (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pinmap_bus_seq i_bus_seq (
    .clk      (stb_clk),
    .rst_n    (rst_sync_n),
    .ctl_sel  (ctl_sel),
    .rd_nwr   (rd_nwr),
    .bus_in   (bus_in),
    .addr_q   (addr_q),
    .wr_en    (wr_en),
    .rd_phase (rd_phase)
  );

  // pin values are loaded on every write-direction strobe
  assign cap_en = ~ctl_sel & ~rd_nwr;

  pinmap_capture #(
    .NUM_PINS (NUM_PINS),
    .NUM_CTRL (NUM_CTRL)
  ) i_capture (
    .cfg     (cfg_q),
    .pin_in  (pin_in),
    .cap_hit (cap_hit),
    .cap_val (cap_val)
  );

  pinmap_regfile #(
    .NUM_PINS (NUM_PINS),
    .NUM_CTRL (NUM_CTRL),
    .NUM_STAT (NUM_STAT)
  ) i_regfile (
    .clk     (stb_clk),
    .rst_n   (rst_sync_n),
    .addr    (addr_q),
    .wr_en   (wr_en),
    .cap_en  (cap_en),
    .wr_cfg  (bus_in[CFG_W-1:0]),
    .wr_ctrl (bus_in[NUM_CTRL-1:0]),
    .cap_hit (cap_hit),
    .cap_val (cap_val),
    .status  (status_in),
    .cfg_q   (cfg_q),
    .ctrl_q  (ctrl_q),
    .rd_data (rd_data)
  );

  // function table seen by the output pins
  always_comb begin
    fn_vec = '0;
    for (int k = 0; k < NUM_CTRL; k++) begin
      fn_vec[CTRL_BASE + k] = ctrl_q[k];
    end
    for (int s = 0; s < NUM_STAT; s++) begin
      fn_vec[STAT_BASE + s] = status_in[s];
    end
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    pinmap_pin_drv i_drv (
      .cfg     (cfg_q[i]),
      .fn_vec  (fn_vec),
      .pin_out (pin_out[i]),
      .pin_oe  (pin_oe[i])
    );
  end

  assign bus_oe   = rd_phase;
  assign bus_out  = rd_phase ? rd_data : '0;
  assign ctrl_out = ctrl_q;

endmodule

// File: rtl/pinmap_checker.sv
module pinmap_checker #(
  parameter int NUM_PINS = 8,
  parameter int NUM_CTRL = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     ctl_sel,
  input logic                     rd_nwr,
  input logic                     bus_oe,
  input logic [NUM_PINS-1:0]      pin_out,
  input logic [NUM_PINS-1:0]      pin_oe,
  input logic [NUM_CTRL-1:0]      ctrl_out,
  input logic [NUM_PINS-1:0][5:0] cfg
);

  logic rst_low_q1;
  logic rst_low_q2;

  always_ff @(posedge clk) begin
    rst_low_q1 <= !rst_n;
    rst_low_q2 <= rst_low_q1;
  end

  // R1
  always @(posedge clk) begin
    if (!rst_n && rst_low_q1 && rst_low_q2) begin
      reset_quiet_chk: assert (pin_oe == '0 && pin_out == '0 && ctrl_out == '0 && !bus_oe);
    end
  end

  // R11
  deselect_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_sel |=> ($stable(ctrl_out) && $stable(pin_oe)));

  // R8
  read_no_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_nwr |=> ($stable(ctrl_out) && $stable(pin_oe)));

  // R8
  bus_oe_read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> (!ctl_sel && rd_nwr));

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_a
    for (genvar j = i + 1; j < NUM_PINS; j++) begin : g_b
      // R5
      shared_out_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg[i] == cfg[j] && cfg[i][5]) |-> (pin_out[i] == pin_out[j]));
    end
  end

endmodule

bind pinmap_top pinmap_checker #(
  .NUM_PINS (NUM_PINS),
  .NUM_CTRL (NUM_CTRL)
) i_chk (
  .clk      (stb_clk),
  .rst_n    (rst_n),
  .ctl_sel  (ctl_sel),
  .rd_nwr   (rd_nwr),
  .bus_oe   (bus_oe),
  .pin_out  (pin_out),
  .pin_oe   (pin_oe),
  .ctrl_out (ctrl_out),
  .cfg      (cfg_q)
);

// File: tb/test_pinmap_top.sv
module test_pinmap_top;

  localparam int CLK_PERIOD = 10;

  logic       stb_clk;
  logic       rst_n;
  logic       ctl_sel;
  logic       rd_nwr;
  logic [9:0] bus_in;
  logic [9:0] bus_out;
  logic       bus_oe;
  logic [7:0] pin_in;
  logic [7:0] pin_out;
  logic [7:0] pin_oe;
  logic [7:0] status_in;
  logic [7:0] ctrl_out;

  int n_cmp = 0;
  int n_bad = 0;

  // fields: pin[18:16] cfg[15:10] status[9:2] exp_out[1] exp_oe[0]
  localparam logic [18:0] VEC [8] = '{
    {3'd0, 6'h30, 8'h01, 1'b1, 1'b1},
    {3'd0, 6'h30, 8'hFE, 1'b0, 1'b1},
    {3'd3, 6'h37, 8'h80, 1'b1, 1'b1},
    {3'd7, 6'h32, 8'h04, 1'b1, 1'b1},
    {3'd5, 6'h12, 8'hFF, 1'b0, 1'b0},
    {3'd2, 6'h20, 8'hFF, 1'b0, 1'b1},
    {3'd6, 6'h3F, 8'hFF, 1'b0, 1'b1},
    {3'd1, 6'h21, 8'hFF, 1'b0, 1'b1}
  };

  pinmap_top i_pinmap_top (
    .stb_clk   (stb_clk),
    .rst_n     (rst_n),
    .ctl_sel   (ctl_sel),
    .rd_nwr    (rd_nwr),
    .bus_in    (bus_in),
    .bus_out   (bus_out),
    .bus_oe    (bus_oe),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .status_in (status_in),
    .ctrl_out  (ctrl_out)
  );

  initial stb_clk = 1'b0;
  always #(CLK_PERIOD / 2) stb_clk = ~stb_clk;

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic sel, input logic rw, input logic [9:0] d);
    @(negedge stb_clk);
    ctl_sel = sel;
    rd_nwr  = rw;
    bus_in  = d;
    @(posedge stb_clk);
    #1;
  endtask

  task automatic park();
    @(negedge stb_clk);
    ctl_sel = 1'b1;
    rd_nwr  = 1'b0;
    bus_in  = '0;
    #1;
  endtask

  task automatic wr(input logic [9:0] a, input logic [9:0] d);
    cyc(1'b0, 1'b0, a);
    cyc(1'b0, 1'b0, d);
    park();
  endtask

  task automatic rd(input logic [9:0] a, input logic [9:0] exp, input string req);
    cyc(1'b0, 1'b0, a);
    @(negedge stb_clk);
    ctl_sel = 1'b0;
    rd_nwr  = 1'b1;
    #1;
    chk({req, " bus_oe in read phase"}, 32'(bus_oe), 32'd1);
    chk({req, " read data"}, 32'(bus_out), 32'(exp));
    @(posedge stb_clk);
    #1;
    park();
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    rst_n     = 1'b0;
    ctl_sel   = 1'b1;
    rd_nwr    = 1'b0;
    bus_in    = '0;
    pin_in    = '0;
    status_in = '0;
    repeat (3) @(posedge stb_clk);
    #1;
    // R1 reset state
    chk("R1 pin_oe", 32'(pin_oe), 32'h0);
    chk("R1 pin_out", 32'(pin_out), 32'h0);
    chk("R1 ctrl_out", 32'(ctrl_out), 32'h0);
    chk("R1 bus_oe", 32'(bus_oe), 32'h0);
    @(negedge stb_clk);
    rst_n = 1'b1;
    repeat (3) @(posedge stb_clk);
    park();

    // R10 R12: null-mapped inputs and unmapped address
    pin_in = 8'hFF;
    wr(10'h3FF, 10'h3FF);
    chk("R10 R12 ctrl unchanged", 32'(ctrl_out), 32'h0);
    rd(10'h3FF, 10'h000, "R12");

    // vector walk: R3 R4 R10
    for (int i = 0; i < 8; i++) begin
      logic [2:0] vp;
      vp = VEC[i][18:16];
      wr(10'h00F + 10'(vp), {4'h0, VEC[i][15:10]});
      status_in = VEC[i][9:2];
      #1;
      chk($sformatf("R4 vec %0d pin_out", i), 32'(pin_out[vp]), 32'(VEC[i][1]));
      chk($sformatf("R3 vec %0d pin_oe", i), 32'(pin_oe[vp]), 32'(VEC[i][0]));
      wr(10'h00F + 10'(vp), 10'h000);
    end
    chk("R10 ctrl after vectors", 32'(ctrl_out), 32'h0);

    // R2 R3 R8: write and read back a config register
    wr(10'h013, 10'h02A);
    chk("R3 pin4 oe after write", 32'(pin_oe), 32'h10);
    cyc(1'b0, 1'b0, 10'h013);
    @(negedge stb_clk);
    ctl_sel = 1'b0;
    rd_nwr  = 1'b0;
    bus_in  = 10'h02A;
    #1;
    chk("R8 bus_oe low in write phase", 32'(bus_oe), 32'h0);
    @(posedge stb_clk);
    #1;
    park();
    rd(10'h013, 10'h02A, "R2");
    chk("R8 bus_oe low after read", 32'(bus_oe), 32'h0);
    wr(10'h013, 10'h000);

    // R9 control and status registers
    wr(10'h000, 10'h0A5);
    chk("R9 ctrl_out", 32'(ctrl_out), 32'hA5);
    rd(10'h000, 10'h0A5, "R9 ctrl");
    status_in = 8'h5A;
    rd(10'h001, 10'h05A, "R9 status");

    // R5 R4: two outputs on one indicator, live follow
    wr(10'h010, 10'h033);
    wr(10'h013, 10'h033);
    status_in = 8'h08;
    #1;
    chk("R5 both pins high", 32'(pin_out & 8'h12), 32'h12);
    status_in = 8'h00;
    #1;
    chk("R4 live follow low", 32'(pin_out & 8'h12), 32'h00);

    // R6 input capture
    pin_in = 8'h00;
    wr(10'h011, 10'h003);
    chk("R6 input pin not driven", 32'(pin_oe[2]), 32'h0);
    chk("R6 no capture before mapped", 32'(ctrl_out), 32'hA5);
    wr(10'h3FF, 10'h000);
    chk("R6 captured low", 32'(ctrl_out), 32'hA1);

    // R11 deselected strobes ignored
    pin_in = 8'h04;
    cyc(1'b1, 1'b0, 10'h000);
    chk("R11 deselect no capture", 32'(ctrl_out), 32'hA1);
    cyc(1'b0, 1'b0, 10'h000);
    cyc(1'b1, 1'b0, 10'h3FF);
    cyc(1'b0, 1'b0, 10'h0FF);
    park();
    chk("R11 phase held across deselect", 32'(ctrl_out), 32'hFF);

    // R7 lowest pin wins
    pin_in = 8'h20;
    wr(10'h014, 10'h003);
    wr(10'h3FF, 10'h000);
    chk("R7 pin2 low wins", 32'(ctrl_out), 32'hFB);
    pin_in = 8'h04;
    wr(10'h3FF, 10'h000);
    chk("R7 pin2 high wins", 32'(ctrl_out), 32'hFF);

    // R1 asynchronous reset mid-run
    rst_n = 1'b0;
    #1;
    chk("R1 async pin_oe", 32'(pin_oe), 32'h0);
    chk("R1 async ctrl", 32'(ctrl_out), 32'h0);
    repeat (2) @(posedge stb_clk);
    report();
  end

endmodule